// File: doc/BRIEF.md
# Page-Write Nonvolatile Memory Cycle Controller

This block models the write side of a byte-wide nonvolatile memory that is programmed a page at a time. A host drives three active-low strobes: select, write and output enable. The block samples them on the system clock through two-stage synchronisers. Each recognised write cycle places one byte into a page buffer, at the offset given by the low address bits. A per-byte valid mask records which offsets were loaded.

A retriggerable window timer decides when loading is over. Every new write cycle restarts it, and it is paused while a cycle is still open. When the window runs out, the block enters a fixed-length programming period and raises `busy`. At the end of that period it commits every loaded byte of the page to the storage array in one step. During programming, the host can poll completion by reading the last written address. That read returns the written byte with its most significant bit inverted. True data comes back once `busy` falls.

Reads go through the same strobes and are registered. `dout_en` stands in for the pad output driver.

Top module: `pgw_eeprom_ctrl`

## Requirements
- R1: After reset, `busy` and `dout_en` are low and every array byte reads 8'hFF.
- R2: A write cycle begins when select and write are both seen low after not both being low, with output enable high. The address is taken at that moment and the data when the first of select or write returns high. If output enable is low at the start, or goes low while the cycle is open, no byte is loaded.
- R3: Each write cycle start restarts a load window of LOAD_CLKS clocks. The window does not count while a cycle is open. Programming begins only when the window expires, so cycles spaced closer than the window form one burst.
- R4: The byte offset within a page is the low PAGE_W address bits. The first byte of a burst fixes the page, given by the upper address bits. Later bytes of the burst that address another page are dropped.
- R5: Only loaded offsets of the page are replaced, all in the same clock at the end of programming. Other bytes keep their contents.
- R6: `busy` stays high for exactly PROG_CLKS clocks per burst, whatever the number of bytes loaded.
- R7: While `busy` is high, a read of the last loaded address returns that byte with bit 7 inverted and bits 6:0 unchanged. Any other address returns the array's current (old) contents.
- R8: With select and output enable low and write high, `dout_en` is high and `dout` carries the read value. In every other case `dout_en` is low and `dout` is 8'h00.
- R9: Write cycles started while `busy` is high load nothing and leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | Output driver enable flag |
| busy | output | 1 | High during the programming period |

## Verification
The assertions assume that `addr` and `din` are stable from a strobe edge until that edge has passed the synchronisers, so the sampled values are the intended ones. They also assume a host does not hold a strobe low long enough to straddle a state change. The bench holds address and data for several clocks around every strobe edge. Within a burst it spaces write cycles well inside the load window, and it starts reads only after prior write strobes are back high. Address and data changes are made mid-strobe only in the capture test, and then long after the sampling point.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pgw_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/pgw_strobe_sync.sv
module pgw_strobe_sync #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1_d, s1_q, s2_d, s2_q;
        always_comb begin
            s1_d = raw[i];
            s2_d = s1_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
            end else begin
                s1_q <= s1_d;
                s2_q <= s2_d;
            end
        end
        assign lvl[i] = s2_q;
    end
endmodule

// File: rtl/pgw_window_timer.sv
module pgw_window_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic run,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          run_d, run_q;

    always_comb begin
        done  = run_q & ~hold & ~start & (cnt_q == LAST);
        cnt_d = cnt_q;
        run_d = run_q;
        if (start) begin
            cnt_d = '0;
            run_d = 1'b1;
        end else if (done) begin
            cnt_d = '0;
            run_d = 1'b0;
        end else if (run_q && !hold) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign run = run_q;

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= LAST)); // R3
    AST_TMR_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !run_q); // R3
    AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (cnt_q == '0)); // R6
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int unsigned PAGE_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PAGE_W-1:0]       off,
    input  logic [7:0]              data,
    input  logic                    clear,
    output logic [(1<<PAGE_W)-1:0]  valid,
    output logic [(8<<PAGE_W)-1:0]  bytes_flat
);
    localparam int unsigned PB = 1 << PAGE_W;

    logic [PB-1:0] vld_d, vld_q;
    logic [7:0]    dat_d [PB];
    logic [7:0]    dat_q [PB];

    always_comb begin
        vld_d = vld_q;
        for (int i = 0; i < PB; i++) dat_d[i] = dat_q[i];
        if (clear) begin
            vld_d = '0;
        end else if (load) begin
            vld_d[off] = 1'b1;
            dat_d[off] = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < PB; i++) dat_q[i] <= '0;
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < PB; i++) dat_q[i] <= dat_d[i];
        end
    end

    assign valid = vld_q;
    for (genvar g = 0; g < PB; g++) begin : g_flat
        assign bytes_flat[g*8 +: 8] = dat_q[g];
    end

    AST_BUF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (vld_q == '0)); // R5
    AST_BUF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> vld_q[$past(off)]); // R4
endmodule

// File: rtl/pgw_store.sv
module pgw_store
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned PAGE_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [ADDR_W-PAGE_W-1:0]   page,
    input  logic [(1<<PAGE_W)-1:0]     valid,
    input  logic [(8<<PAGE_W)-1:0]     bytes_flat,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PB    = 1 << PAGE_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (commit) begin
            for (int o = 0; o < PB; o++) begin
                if (valid[o]) mem_d[{page, PAGE_W'(o)}] = bytes_flat[o*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pgw_eeprom_ctrl.sv
module pgw_eeprom_ctrl
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned PAGE_W    = 6,
    parameter int unsigned LOAD_CLKS = 18750,
    parameter int unsigned PROG_CLKS = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int unsigned PGN_W = ADDR_W - PAGE_W;
    localparam int unsigned PB    = 1 << PAGE_W;

    typedef struct packed {
        pgw_state_e        st;
        logic              open;
        logic              sel;
        logic [ADDR_W-1:0] cyc_addr;
        logic [ADDR_W-1:0] last_addr;
        logic [7:0]        last_data;
        logic [PGN_W-1:0]  page;
        logic [7:0]        dout;
        logic              den;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [2:0]        lvl;
    logic              cs_l, we_l, oe_l;
    logic              cyc_start, cyc_end, buf_load, commit;
    logic              ld_start, ld_done, ld_run, pg_start, pg_done, pg_run;
    logic [PB-1:0]     buf_valid;
    logic [8*PB-1:0]   buf_bytes;
    logic [7:0]        mem_rd;
    logic              in_page, rd_sel, poll_hit;

    pgw_strobe_sync #(.N(3)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw({oe_n, we_n, cs_n}), .lvl(lvl)
    );

    assign cs_l = lvl[0];
    assign we_l = lvl[1];
    assign oe_l = lvl[2];

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.sel = ~cs_l & ~we_l;

        cyc_start = ~cs_l & ~we_l & ~ctl_q.sel & oe_l
                    & (ctl_q.st != ST_PROG) & ~ctl_q.open;
        cyc_end   = ctl_q.open & (cs_l | we_l);
        in_page   = (ctl_q.cyc_addr[ADDR_W-1:PAGE_W] == ctl_q.page);
        buf_load  = cyc_end & oe_l &
                    ((ctl_q.st == ST_IDLE) || ((ctl_q.st == ST_LOAD) && in_page));
        ld_start  = ((ctl_q.st == ST_IDLE) & buf_load) |
                    ((ctl_q.st == ST_LOAD) & cyc_start);
        pg_start  = (ctl_q.st == ST_LOAD) & ld_done;
        commit    = (ctl_q.st == ST_PROG) & pg_done;

        if (cyc_start) begin
            ctl_d.open     = 1'b1;
            ctl_d.cyc_addr = addr;
        end else if (ctl_q.open && (cyc_end || !oe_l)) begin
            ctl_d.open = 1'b0;
        end

        if (buf_load) begin
            ctl_d.last_addr = ctl_q.cyc_addr;
            ctl_d.last_data = din;
        end

        unique case (ctl_q.st)
            ST_IDLE: if (buf_load) begin
                ctl_d.st   = ST_LOAD;
                ctl_d.page = ctl_q.cyc_addr[ADDR_W-1:PAGE_W];
            end
            ST_LOAD: if (ld_done) ctl_d.st = ST_PROG;
            ST_PROG: if (pg_done) ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase

        rd_sel   = ~cs_l & ~oe_l & we_l;
        poll_hit = (ctl_q.st == ST_PROG) && (addr == ctl_q.last_addr);
        ctl_d.den  = rd_sel;
        ctl_d.dout = 8'h00;
        if (rd_sel) begin
            ctl_d.dout = poll_hit ? {~ctl_q.last_data[7], ctl_q.last_data[6:0]} : mem_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pgw_window_timer #(.LIMIT(LOAD_CLKS)) load_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(ld_start), .hold(ctl_q.open),
        .run(ld_run), .done(ld_done)
    );

    pgw_window_timer #(.LIMIT(PROG_CLKS)) prog_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(pg_start), .hold(1'b0),
        .run(pg_run), .done(pg_done)
    );

    pgw_page_buf #(.PAGE_W(PAGE_W)) buf_i (
        .clk(clk), .rst_n(rst_n), .load(buf_load),
        .off(ctl_q.cyc_addr[PAGE_W-1:0]), .data(din), .clear(commit),
        .valid(buf_valid), .bytes_flat(buf_bytes)
    );

    pgw_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) store_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(ctl_q.page),
        .valid(buf_valid), .bytes_flat(buf_bytes), .rd_addr(addr), .rd_data(mem_rd)
    );

    assign dout    = ctl_q.dout;
    assign dout_en = ctl_q.den;
    assign busy    = (ctl_q.st == ST_PROG);

    AST_PROG_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ctl_q.st) == ST_LOAD) && !ld_run); // R3
    AST_LOAD_HAS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LOAD) |-> ld_run); // R3
    AST_BUSY_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> pg_run); // R6
    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_load); // R9
    AST_COMMIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (buf_valid != '0)); // R5
    AST_READ_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !ctl_q.open); // R8
    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_en) |-> (dout == 8'h00)); // R8
endmodule

// File: tb/pgw_eeprom_ctrl_tb_top.sv
module pgw_eeprom_ctrl_tb_top;
    localparam int AW = 6;
    localparam int PW = 3;
    localparam int LD = 30;
    localparam int PG = 60;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, busy;

    int total = 0;
    int bad = 0;
    int run_len = 0;
    int last_len = 0;
    bit busy_seen = 0;
    logic [7:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    pgw_eeprom_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .LOAD_CLKS(LD), .PROG_CLKS(PG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    always @(negedge clk) begin
        if (busy) begin
            run_len = run_len + 1;
            busy_seen = 1;
        end else if (run_len != 0) begin
            last_len = run_len;
            run_len = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit cs_ctl);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1;
        if (cs_ctl) begin we_n = 1'b0; tick(2); cs_n = 1'b0; end
        else begin cs_n = 1'b0; tick(2); we_n = 1'b0; end
        tick(5);
        if (cs_ctl) cs_n = 1'b1; else we_n = 1'b1;
        tick(1);
        cs_n = 1'b1; we_n = 1'b1;
        tick(4);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic en);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        tick(5);
        v = dout; en = dout_en;
        cs_n = 1'b1; oe_n = 1'b1;
        tick(3);
    endtask

    task automatic wait_busy_rise(output int waited);
        waited = 0;
        while (!busy && waited < 400) begin tick(1); waited++; end
    endtask

    task automatic wait_busy_fall();
        int w = 0;
        while (busy && w < PG + 100) begin tick(1); w++; end
        tick(2);
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v; logic en;
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i), v, en);
            chk(en === 1'b1 && v === exp_mem[i], tag, v, exp_mem[i]);
        end
    endtask

    initial begin
        #(8ns * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v; logic en;
        int w;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(dout_en === 1'b0, "R1 dout_en after reset", dout_en, 0);
        sweep("R1 erased contents");

        // Full page 0, write-strobe controlled; poll and blocked write during programming
        for (int i = 0; i < 8; i++) wr(AW'(i), 8'(i * 37 + 5), 1'b0);
        wait_busy_rise(w);
        chk(busy === 1'b1, "R6 busy after full page", busy, 1);
        rd(AW'(7), v, en);
        chk(v === (8'(7 * 37 + 5) ^ 8'h80), "R7 poll last address", v, 8'(7 * 37 + 5) ^ 8'h80);
        rd(AW'(2), v, en);
        chk(v === 8'hFF, "R7 other address old data", v, 8'hFF);
        wr(AW'(6'h28), 8'h11, 1'b0); // R9: attempt during programming
        wait_busy_fall();
        chk(last_len == PG, "R6 busy length full page", last_len, PG);
        for (int i = 0; i < 8; i++) exp_mem[i] = 8'(i * 37 + 5);
        sweep("R5 R9 after full page");

        // Partial page 1, select-strobe controlled, with a stray byte to page 3
        wr(AW'(8 + 1), 8'h3C, 1'b1);
        wr(AW'(24 + 2), 8'hE7, 1'b1); // R4: other page, dropped
        wr(AW'(8 + 4), 8'hA5, 1'b1);
        wr(AW'(8 + 6), 8'h00, 1'b1);
        wait_busy_rise(w);
        rd(AW'(8 + 6), v, en);
        chk(v === 8'h80, "R7 poll zero byte", v, 8'h80);
        wait_busy_fall();
        chk(last_len == PG, "R6 busy length partial page", last_len, PG);
        exp_mem[9] = 8'h3C; exp_mem[12] = 8'hA5; exp_mem[14] = 8'h00;
        sweep("R4 R5 after partial page");

        // R2: output enable low inhibits the write
        busy_seen = 0;
        @(negedge clk);
        addr = AW'(6'h30); din = 8'h42; oe_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
        tick(10);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        tick(LD + 20);
        chk(busy_seen == 0, "R2 no programming with oe low", busy_seen, 0);
        rd(AW'(6'h30), v, en);
        chk(v === 8'hFF, "R2 inhibited byte unchanged", v, 8'hFF);

        // R2: address at cycle start, data at first strobe rise
        @(negedge clk);
        addr = AW'(6'h10); din = 8'hAA; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
        tick(6);
        addr = AW'(6'h13); din = 8'h5C;
        tick(5);
        we_n = 1'b1; cs_n = 1'b1;
        tick(4);
        wait_busy_rise(w);
        wait_busy_fall();
        exp_mem[6'h10] = 8'h5C;
        rd(AW'(6'h10), v, en);
        chk(v === 8'h5C, "R2 data taken at strobe rise", v, 8'h5C);
        rd(AW'(6'h13), v, en);
        chk(v === 8'hFF, "R2 address taken at strobe fall", v, 8'hFF);

        // R3: retriggered window keeps one burst
        busy_seen = 0;
        for (int i = 0; i < 4; i++) begin
            wr(AW'(6'h20 + i * 2), 8'(8'h71 + i), 1'b0);
            tick(12);
            chk(busy_seen == 0, "R3 window retriggered", busy_seen, 0);
            exp_mem[6'h20 + i * 2] = 8'(8'h71 + i);
        end
        wait_busy_rise(w);
        w = w + 12;
        chk(w >= LD - 8 && w <= LD + 2, "R3 window length", w, LD);
        wait_busy_fall();
        chk(last_len == PG, "R6 busy length retrigger burst", last_len, PG);
        sweep("R3 R5 after retrigger burst");

        // R8: output disabled unless select and output enable both low
        @(negedge clk);
        addr = AW'(0); cs_n = 1'b1; oe_n = 1'b0;
        tick(5);
        chk(dout_en === 1'b0 && dout === 8'h00, "R8 no select", dout, 0);
        cs_n = 1'b0; oe_n = 1'b1;
        tick(5);
        chk(dout_en === 1'b0 && dout === 8'h00, "R8 no output enable", dout, 0);
        cs_n = 1'b1;
        tick(3);
        rd(AW'(3), v, en);
        chk(en === 1'b1 && v === exp_mem[3], "R8 read drives data", v, exp_mem[3]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule